// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block walks a DDR2 SDRAM device through its power-up and mode-programming sequence once, after reset, and then hands over to normal operation. A single start pulse launches the run. The geometry and decode inputs are captured at that moment. The block then issues fifteen steps, one after another. For each step it presents a command code, a bank number, the linear address that puts the bank number at the bank-select bit position, and two mode payload bits: DLL reset and OCD default.

The bank-select bit position is derived from the column-bit code, the row-bit code, the interleaved-decode flag and the half-width bus flag. The first two steps are separated by a fixed 200 us power-up wait, counted in clock cycles from a clock-frequency parameter. Every later step is held for a parameterised minimum number of cycles, which covers precharge, mode-set and refresh recovery. After the final dummy write, the block raises `done` and drives the captured refresh-rate value.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, and until a start pulse, `cmd_valid`, `done` and `refresh_out` are all 0.
- R2: A run issues exactly 15 commands, each flagged by a one-cycle `cmd_valid`, in this order (cmd code in brackets): NOP[1], NOP[1], precharge-all[2], EMRS[4], EMRS[4], EMRS[4], MRS[3], precharge-all[2], refresh[5], refresh[5], MRS[3], EMRS[4], EMRS[4], normal-mode[6], dummy write[7].
- R3: The first command appears one cycle after the start pulse is sampled. The second command follows it exactly CLK_MHZ*WAIT_US cycles later (10000 cycles by default).
- R4: Every later command follows the one before it by exactly STEP_CYC cycles.
- R5: `dll_reset` is 1 on the first MRS and 0 on every other command, including the second MRS.
- R6: `ocd_default` is 1 only on the first EMRS issued after the second MRS (command 12), and 0 on the EMRS that follows it.
- R7: `bank_shift` equals col_code + 9, plus row_code + 11 when `interleave` is 0, plus 1 when `half_width` is 1 or 2 when it is 0.
- R8: The three early EMRS commands carry banks 2, 3 and 1, and both late EMRS commands carry bank 1. Every other command carries bank 0. `cmd_addr` always equals bank shifted left by `bank_shift`.
- R9: `done` rises exactly one cycle after the dummy write. `refresh_out` then holds the refresh rate captured at start, and no command is issued after `done`.
- R10: A start pulse while a run is in progress or after `done` is ignored, and `done` stays 1 until reset.
- R11: Configuration inputs that change after the start pulse have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse |
| col_code | input | 2 | Column-bit code (9 + code column bits) |
| row_code | input | 2 | Row-bit code (11 + code row bits) |
| interleave | input | 1 | 1 = interleaved bank decode |
| half_width | input | 1 | 1 = half-width data bus |
| refresh_rate | input | RR_W | Refresh rate, passed through on completion |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd | output | 3 | Command code |
| bank | output | 2 | Bank number for the command |
| cmd_addr | output | ADDR_W | Linear address carrying the bank number |
| bank_shift | output | 5 | Bank-select bit position |
| dll_reset | output | 1 | Mode payload DLL-reset bit |
| ocd_default | output | 1 | Mode payload OCD-default bit |
| done | output | 1 | Sequence complete, sticky until reset |
| refresh_out | output | RR_W | Captured refresh rate, valid with done |

## Verification
The assertions check, on every cycle, the rules that can be stated locally:
- the minimum 200 us spacing after the first command;
- the minimum step spacing;
- the confinement of the DLL-reset bit to MRS and of the OCD bit to EMRS on bank 1;
- bank 0 on every non-EMRS command;
- the cap of fifteen commands;
- the stickiness of `done`.

The exact fifteen-step order, exact gap lengths, bank-shift arithmetic across geometries, and immunity to stray start pulses and to configuration changes during a run are only shown by the bench's scenarios. These compare each recorded command against a model of the sequence.

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq #(
  parameter int CLK_MHZ  = 50,
  parameter int WAIT_US  = 200,
  parameter int STEP_CYC = 4,
  parameter int ADDR_W   = 32,
  parameter int RR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        col_code,
  input  logic [1:0]        row_code,
  input  logic              interleave,
  input  logic              half_width,
  input  logic [RR_W-1:0]   refresh_rate,
  output logic              cmd_valid,
  output logic [2:0]        cmd,
  output logic [1:0]        bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [4:0]        bank_shift,
  output logic              dll_reset,
  output logic              ocd_default,
  output logic              done,
  output logic [RR_W-1:0]   refresh_out
);
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int TMR_W    = $clog2(WAIT_CYC + STEP_CYC + 1);
  localparam logic [3:0] LAST = 4'd14;

  localparam logic [2:0] C_NONE = 3'd0, C_NOP = 3'd1, C_PALL = 3'd2, C_MRS = 3'd3,
                         C_EMRS = 3'd4, C_REF = 3'd5, C_NORM = 3'd6, C_WR = 3'd7;

  logic             busy;
  logic [3:0]       step;
  logic [TMR_W-1:0] tmr;
  logic [1:0]       col_q, row_q;
  logic             il_q, hw_q;
  logic [RR_W-1:0]  rr_q;

  assign cmd_valid  = busy && (tmr == '0);
  assign bank_shift = 5'(col_q) + 5'd9 + (il_q ? 5'd0 : 5'(row_q) + 5'd11) + (hw_q ? 5'd1 : 5'd2);
  assign cmd_addr   = ADDR_W'(bank) << bank_shift;

  always_comb begin
    cmd = C_NONE; bank = 2'd0; dll_reset = 1'b0; ocd_default = 1'b0;
    case (step)
      4'd0, 4'd1: cmd = C_NOP;
      4'd2, 4'd7: cmd = C_PALL;
      4'd3:  begin cmd = C_EMRS; bank = 2'd2; end
      4'd4:  begin cmd = C_EMRS; bank = 2'd3; end
      4'd5:  begin cmd = C_EMRS; bank = 2'd1; end
      4'd6:  begin cmd = C_MRS;  dll_reset = 1'b1; end
      4'd8, 4'd9: cmd = C_REF;
      4'd10: cmd = C_MRS;
      4'd11: begin cmd = C_EMRS; bank = 2'd1; ocd_default = 1'b1; end
      4'd12: begin cmd = C_EMRS; bank = 2'd1; end
      4'd13: cmd = C_NORM;
      4'd14: cmd = C_WR;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; step <= '0; tmr <= '0;
      col_q <= '0; row_q <= '0; il_q <= 1'b0; hw_q <= 1'b0;
      rr_q <= '0; refresh_out <= '0;
    end else if (!busy && !done) begin
      if (start) begin
        busy  <= 1'b1; step <= '0; tmr <= '0;
        col_q <= col_code; row_q <= row_code;
        il_q  <= interleave; hw_q <= half_width; rr_q <= refresh_rate;
      end
    end else if (busy) begin
      if (cmd_valid) begin
        step <= step + 4'd1;
        tmr  <= (step == 4'd0) ? TMR_W'(WAIT_CYC - 1) : TMR_W'(STEP_CYC - 1);
        if (step == LAST) begin
          busy <= 1'b0; done <= 1'b1; refresh_out <= rr_q;
        end
      end else begin
        tmr <= tmr - 1'b1;
      end
    end
  end
endmodule

module ddr2_init_seq_chk #(
  parameter int CLK_MHZ  = 50,
  parameter int WAIT_US  = 200,
  parameter int STEP_CYC = 4,
  parameter int RR_W     = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [2:0]      cmd,
  input logic [1:0]      bank,
  input logic            dll_reset,
  input logic            ocd_default,
  input logic            done,
  input logic [RR_W-1:0] refresh_out
);
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  logic [31:0] gap;
  logic [4:0]  ncmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; ncmd <= '0;
    end else begin
      if (cmd_valid) begin
        gap <= 32'd1;
        ncmd <= ncmd + 5'd1;
      end else if (gap != 32'hFFFF_FFFF) begin
        gap <= gap + 32'd1;
      end
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R10
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !cmd_valid); // R9
  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> refresh_out == '0); // R9
  AST_POWERUP_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && ncmd == 5'd1) |-> gap >= 32'(WAIT_CYC)); // R3
  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && ncmd > 5'd1) |-> gap >= 32'(STEP_CYC)); // R4
  AST_DLL_ON_MRS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && dll_reset) |-> cmd == 3'd3); // R5
  AST_OCD_ON_EMRS1: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && ocd_default) |-> (cmd == 3'd4 && bank == 2'd1)); // R6
  AST_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd != 3'd4) |-> bank == 2'd0); // R8
  AST_CMD_CAP: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> ncmd < 5'd15); // R2
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
  .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .STEP_CYC(STEP_CYC), .RR_W(RR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .bank(bank),
  .dll_reset(dll_reset), .ocd_default(ocd_default), .done(done), .refresh_out(refresh_out)
);

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;
  localparam int WAIT_CYC = 50 * 200;
  localparam int STEP     = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] col_code = '0, row_code = '0;
  logic interleave = 1'b0, half_width = 1'b0;
  logic [11:0] refresh_rate = '0;
  logic cmd_valid, dll_reset, ocd_default, done;
  logic [2:0] cmd;
  logic [1:0] bank;
  logic [31:0] cmd_addr;
  logic [4:0] bank_shift;
  logic [11:0] refresh_out;

  ddr2_init_seq dut (.*);

  always #10 clk = ~clk;

  int cyc = 0, nchk = 0, nerr = 0, ev_n = 0, done_cyc = -1;
  int ev_cyc[32];
  int ev_cmd[32], ev_bank[32], ev_dll[32], ev_ocd[32];
  longint ev_addr[32];
  int ev_shift[32];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cmd_valid) begin
      if (ev_n < 32) begin
        ev_cyc[ev_n] = cyc; ev_cmd[ev_n] = cmd; ev_bank[ev_n] = bank;
        ev_dll[ev_n] = dll_reset; ev_ocd[ev_n] = ocd_default;
        ev_addr[ev_n] = cmd_addr; ev_shift[ev_n] = bank_shift;
      end
      ev_n++;
    end
    if (done && done_cyc < 0) done_cyc = cyc;
  end

  always @(posedge clk) if (cyc > 190000) begin
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=<190000", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_shift(int c, int r, bit il, bit hw);
    return c + 9 + (il ? 0 : r + 11) + (hw ? 1 : 2);
  endfunction

  function automatic int exp_cmd(int i);
    case (i)
      0, 1: return 1; 2, 7: return 2; 6, 10: return 3;
      3, 4, 5, 11, 12: return 4; 8, 9: return 5; 13: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic int exp_bank(int i);
    case (i)
      3: return 2; 4: return 3; 5, 11, 12: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic run_seq(input int c, input int r, input bit il, input bit hw,
                         input int rr, input bit disturb);
    int s, sh;
    rst_n = 1'b0; start = 1'b0;
    col_code = 2'(c); row_code = 2'(r); interleave = il; half_width = hw;
    refresh_rate = 12'(rr);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ev_n = 0; done_cyc = -1;
    chk("R1 done", done, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 refresh_out", refresh_out, 0);
    repeat (5) @(negedge clk);
    chk("R1 no command before start", ev_n, 0);
    start = 1'b1; s = cyc;
    for (int k = 1; k < WAIT_CYC + 300; k++) begin
      @(negedge clk);
      start = disturb && (k == 500 || k == WAIT_CYC + 20 || k == WAIT_CYC + 37);
      if (disturb && k == 100) begin
        col_code = ~col_code; row_code = ~row_code;
        interleave = ~interleave; half_width = ~half_width; refresh_rate = ~refresh_rate;
      end
      if (done) break;
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    sh = exp_shift(c, r, il, hw);
    chk("R2 command count", ev_n, 15);
    for (int i = 0; i < 15 && i < ev_n; i++) begin
      chk($sformatf("R2 cmd step %0d", i), ev_cmd[i], exp_cmd(i));
      chk($sformatf("R8 bank step %0d", i), ev_bank[i], exp_bank(i));
      chk($sformatf("R7 R11 shift step %0d", i), ev_shift[i], sh);
      chk($sformatf("R8 addr step %0d", i), ev_addr[i], longint'(exp_bank(i)) << sh);
      chk($sformatf("R5 dll step %0d", i), ev_dll[i], (i == 6) ? 1 : 0);
      chk($sformatf("R6 ocd step %0d", i), ev_ocd[i], (i == 11) ? 1 : 0);
      if (i == 0) chk("R3 first command delay", ev_cyc[0] - s, 1);
      else if (i == 1) chk("R3 power-up wait", ev_cyc[1] - ev_cyc[0], WAIT_CYC);
      else chk($sformatf("R4 gap step %0d", i), ev_cyc[i] - ev_cyc[i-1], STEP);
    end
    if (ev_n >= 15) chk("R9 done timing", done_cyc - ev_cyc[14], 1);
    chk("R9 R11 refresh_out", refresh_out, rr);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 start after done ignored", ev_n, 15);
    chk("R10 done sticky", done, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_seq(0, 0, 1'b1, 1'b1, 12'h001, 1'b0);
    run_seq(3, 3, 1'b0, 1'b0, 12'hFFF, 1'b0);
    run_seq(2, 1, 1'b0, 1'b1, 12'h5A3, 1'b1);
    for (int n = 0; n < 4; n++)
      run_seq(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              int'($urandom_range(0, 4095)), 1'($urandom_range(0, 1)));
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule